// File: doc/BRIEF.md
# Peripheral Interrupt Priority Resolver

This block collects level-sensitive, active-low interrupt lines from a set of on-chip peripherals. Each line has an enable bit and a programmable 5-bit priority. Every cycle it picks the single best source and hands the CPU a 4-bit request level together with an exception code that names that source. A handler can then branch on the code without reading any status register.

Sources are ranked at full 5-bit resolution. The level reported to the CPU is the winning priority with its lowest bit removed. The two lowest 5-bit settings both mean the source is masked. When two sources have equal 5-bit priority, the lower source index wins.

The request output also takes the CPU's block bit and current mask level into account. It is raised only when the CPU could actually take the interrupt. Priorities and enables are loaded through a single-entry write port.

Top module: `irq_prio_resolver`

## Requirements
- R1: While rst_n is low at a clock edge, all enables and priorities clear to 0. After that edge, irq_level, irq_code and irq_req read 0.
- R2: With wr_en high at a clock edge, source wr_sel takes wr_enable as its enable bit and wr_prio as its 5-bit priority. No other source's settings change.
- R3: A source whose priority is 0x00 or 0x01 never wins, whatever its line and enable.
- R4: A source qualifies when its line is low, its enable is 1 and its priority is at least 0x02. Among qualifying sources, the one with the largest 5-bit priority wins, so 0x1B beats 0x1A.
- R5: irq_level equals bits [4:1] of the winner's priority. Both 0x1A and 0x1B report 0xD.
- R6: Among qualifying sources with equal 5-bit priority, the lowest source index wins.
- R7: irq_code for winning source i equals CODE_BASE + i*CODE_STEP. The defaults are 0x400 and 0x20, so source 5 gives 0x4A0.
- R8: When no source qualifies, irq_level and irq_code are both 0.
- R9: A pending request is not retained. When a line returns high, its source no longer competes from the next registered result on.
- R10: irq_req is 1 exactly when cpu_block is 0 and irq_level is strictly greater than cpu_mask. This output follows cpu_block and cpu_mask in the same cycle.
- R11: irq_level and irq_code are registered. A change on the lines, or in the stored settings, appears on them one clock edge later, and not before that edge.
- R12: A source whose enable is 0 never wins, whatever its line and priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_req_n | input | N_SRC | Active-low interrupt lines, one per source |
| wr_en | input | 1 | Write strobe for one source's settings |
| wr_sel | input | IDX_W | Index of the source being written |
| wr_enable | input | 1 | Enable bit to store |
| wr_prio | input | 5 | Priority to store |
| cpu_block | input | 1 | CPU blocks all interrupts when 1 |
| cpu_mask | input | 4 | CPU's current mask level |
| irq_req | output | 1 | Interrupt request to the CPU |
| irq_level | output | 4 | Reported request level |
| irq_code | output | CODE_W | Exception code of the winning source |

## Verification
The hardest case to reach from the ports is a pair of sources that report the same 4-bit level but differ in the 5-bit priority's low bit. A related case is a pair that tie exactly and must be split by index. To reach these, the stimulus first programs two sources, one at 0x1A and one at 0x1B, with the higher priority on the higher index, so that ranking and index order disagree. It then rewrites one priority so the two tie exactly. Line withdrawal and one-edge latency are exposed by changing a line at a falling edge and sampling both before and after the next rising edge.

// File: rtl/irqp_pkg.sv
// Shared constants and types for the peripheral interrupt priority resolver.
// Assumes a 5-bit priority field reported as a 4-bit level.
package irqp_pkg;
    localparam int PRIO_W   = 5;
    localparam int LVL_W    = PRIO_W - 1;
    localparam int PRIO_MIN = 2;   // lowest priority value that can request

    typedef logic [PRIO_W-1:0] prio_t;
    typedef logic [LVL_W-1:0]  lvl_t;
endpackage

// File: rtl/irqp_cfg_regs.sv
// Per-source enable and priority storage, written one entry at a time.
// Assumes wr_sel is below N_SRC whenever wr_en is high.
module irqp_cfg_regs
    import irqp_pkg::*;
#(
    parameter int N_SRC = 8,
    localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_sel,
    input  logic             wr_enable,
    input  prio_t            wr_prio,
    output logic [N_SRC-1:0] en_q,
    output prio_t            prio_q [N_SRC]
);

    genvar g;
    generate
        for (g = 0; g < N_SRC; g++) begin : g_ent
            // Holds one source's settings; loads on a matching write.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    en_q[g]   <= 1'b0;
                    prio_q[g] <= '0;
                end else if (wr_en && (wr_sel == IDX_W'(g))) begin
                    en_q[g]   <= wr_enable;
                    prio_q[g] <= wr_prio;
                end
            end
        end
    endgenerate

    // R2
    wr_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (prio_q[$past(wr_sel)] == $past(wr_prio)) && (en_q[$past(wr_sel)] == $past(wr_enable)));

endmodule

// File: rtl/irqp_arbiter.sv
// Combinational priority chain: finds the qualifying source with the largest
// 5-bit priority. A later source replaces the running best only on a strictly
// higher priority, so equal priorities keep the lower index.
module irqp_arbiter
    import irqp_pkg::*;
#(
    parameter int N_SRC = 8,
    localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic [N_SRC-1:0] src_req_n,
    input  logic [N_SRC-1:0] en_q,
    input  prio_t            prio_q [N_SRC],
    output logic             win_valid,
    output logic [IDX_W-1:0] win_idx,
    output prio_t            win_prio
);

    logic             bst_valid [N_SRC+1];
    logic [IDX_W-1:0] bst_idx   [N_SRC+1];
    prio_t            bst_prio  [N_SRC+1];

    assign bst_valid[0] = 1'b0;
    assign bst_idx[0]   = '0;
    assign bst_prio[0]  = '0;

    genvar g;
    generate
        for (g = 0; g < N_SRC; g++) begin : g_link
            logic qual;
            logic take;
            // Source is live, enabled and above the masked range.
            assign qual = !src_req_n[g] && en_q[g] && (prio_q[g] >= prio_t'(PRIO_MIN));
            // Replace the running best only on strictly higher priority.
            assign take = qual && (!bst_valid[g] || (prio_q[g] > bst_prio[g]));
            assign bst_valid[g+1] = bst_valid[g] || qual;
            assign bst_idx[g+1]   = take ? IDX_W'(g)  : bst_idx[g];
            assign bst_prio[g+1]  = take ? prio_q[g]  : bst_prio[g];
        end
    endgenerate

    assign win_valid = bst_valid[N_SRC];
    assign win_idx   = bst_idx[N_SRC];
    assign win_prio  = bst_prio[N_SRC];

endmodule

// File: rtl/irqp_out_stage.sv
// Registers the arbitration result as a 4-bit level and an exception code,
// and gates the request against the CPU's block bit and mask level.
// Assumes CODE_BASE + (N_SRC-1)*CODE_STEP fits in CODE_W and is nonzero.
module irqp_out_stage
    import irqp_pkg::*;
#(
    parameter int N_SRC     = 8,
    parameter int CODE_W    = 12,
    parameter int CODE_BASE = 'h400,
    parameter int CODE_STEP = 'h20,
    localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              win_valid,
    input  logic [IDX_W-1:0]  win_idx,
    input  prio_t             win_prio,
    input  logic              cpu_block,
    input  lvl_t              cpu_mask,
    output logic              irq_req,
    output lvl_t              irq_level,
    output logic [CODE_W-1:0] irq_code
);

    localparam logic [CODE_W-1:0] BASE_C = CODE_W'(CODE_BASE);
    localparam logic [CODE_W-1:0] STEP_C = CODE_W'(CODE_STEP);

    logic [CODE_W-1:0] code_d;

    // Exception code of the current winner, computed from its index.
    always_comb begin
        code_d = BASE_C + (CODE_W'(win_idx) * STEP_C);
    end

    // Registers level and code; both zero when nothing qualifies.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_level <= '0;
            irq_code  <= '0;
        end else if (win_valid) begin
            irq_level <= win_prio[PRIO_W-1:1];
            irq_code  <= code_d;
        end else begin
            irq_level <= '0;
            irq_code  <= '0;
        end
    end

    // Request only when the CPU could accept at this level.
    always_comb begin
        irq_req = !cpu_block && (irq_level > cpu_mask);
    end

    // R3
    win_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> (win_prio >= prio_t'(PRIO_MIN)));

    // R8
    idle_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_level == '0) |-> (irq_code == '0));

    // R7
    live_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_level != '0) |-> (irq_code != '0));

    // R10
    block_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_block |-> !irq_req);

    // R11
    level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !win_valid |=> (irq_level == '0));

endmodule

// File: rtl/irq_prio_resolver.sv
// Top of the peripheral interrupt priority resolver: settings storage, a
// priority chain and a registered output stage. Lines are active low and
// level sensitive; nothing is latched, so a withdrawn line stops competing.
module irq_prio_resolver
    import irqp_pkg::*;
#(
    parameter int N_SRC     = 8,
    parameter int CODE_W    = 12,
    parameter int CODE_BASE = 'h400,
    parameter int CODE_STEP = 'h20,
    localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  src_req_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_sel,
    input  logic              wr_enable,
    input  logic [4:0]        wr_prio,
    input  logic              cpu_block,
    input  logic [3:0]        cpu_mask,
    output logic              irq_req,
    output logic [3:0]        irq_level,
    output logic [CODE_W-1:0] irq_code
);

    logic [N_SRC-1:0] en_q;
    prio_t            prio_q [N_SRC];
    logic             win_valid;
    logic [IDX_W-1:0] win_idx;
    prio_t            win_prio;

    irqp_cfg_regs #(.N_SRC(N_SRC)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_enable (wr_enable),
        .wr_prio   (wr_prio),
        .en_q      (en_q),
        .prio_q    (prio_q)
    );

    irqp_arbiter #(.N_SRC(N_SRC)) u_arb (
        .src_req_n (src_req_n),
        .en_q      (en_q),
        .prio_q    (prio_q),
        .win_valid (win_valid),
        .win_idx   (win_idx),
        .win_prio  (win_prio)
    );

    irqp_out_stage #(
        .N_SRC     (N_SRC),
        .CODE_W    (CODE_W),
        .CODE_BASE (CODE_BASE),
        .CODE_STEP (CODE_STEP)
    ) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .win_valid (win_valid),
        .win_idx   (win_idx),
        .win_prio  (win_prio),
        .cpu_block (cpu_block),
        .cpu_mask  (cpu_mask),
        .irq_req   (irq_req),
        .irq_level (irq_level),
        .irq_code  (irq_code)
    );

endmodule

// File: tb/sim_irq_prio_resolver.sv
`timescale 1ns/1ps
// Bench: a behavioural model updated at each rising edge, compared with the
// outputs 1 ns after every falling edge, plus directed checks per requirement.
module sim_irq_prio_resolver;
    localparam int N = 8;
    localparam int CW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  src_req_n = '1;
    logic          wr_en = 1'b0;
    logic [2:0]    wr_sel = '0;
    logic          wr_enable = 1'b0;
    logic [4:0]    wr_prio = '0;
    logic          cpu_block = 1'b0;
    logic [3:0]    cpu_mask = '0;
    logic          irq_req;
    logic [3:0]    irq_level;
    logic [CW-1:0] irq_code;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    // Model state.
    int m_en   [N];
    int m_prio [N];
    int exp_level = 0;
    int exp_code  = 0;

    always #5 clk = ~clk;

    irq_prio_resolver #(.N_SRC(N), .CODE_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .src_req_n(src_req_n),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_enable(wr_enable), .wr_prio(wr_prio),
        .cpu_block(cpu_block), .cpu_mask(cpu_mask),
        .irq_req(irq_req), .irq_level(irq_level), .irq_code(irq_code)
    );

    task automatic chk(input string tag, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", tag, got, exp, $time);
        end
    endtask

    // Model: the winner is searched from the top priority down, first index wins.
    always @(posedge clk) begin
        int found;
        found = 0;
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin m_en[i] = 0; m_prio[i] = 0; end
            exp_level = 0; exp_code = 0;
        end else begin
            exp_level = 0; exp_code = 0;
            for (int p = 31; p >= 2 && found == 0; p--)
                for (int i = 0; i < N && found == 0; i++)
                    if (src_req_n[i] == 1'b0 && m_en[i] == 1 && m_prio[i] == p) begin
                        found = 1;
                        exp_level = p / 2;
                        exp_code = 'h400 + i * 'h20;
                    end
            if (wr_en) begin
                m_en[wr_sel]   = int'(wr_enable);
                m_prio[wr_sel] = int'(wr_prio);
            end
        end
    end

    // Per-cycle comparison against the model (R11 timing, R10 gating).
    always begin
        @(negedge clk);
        #1;
        if (rst_n) begin
            chk("R11 level", int'(irq_level), exp_level);
            chk("R11 code", int'(irq_code), exp_code);
            chk("R10 req", int'(irq_req), int'(cpu_block == 1'b0 && exp_level > int'(cpu_mask)));
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            total++; bad++;
            $display("FAIL watchdog: got hang expected finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic wr(input int idx, input bit en, input int prio);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 3'(idx); wr_enable = en; wr_prio = 5'(prio);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Waits past the next rising edge, to sample after the output register.
    task automatic settle();
        @(negedge clk);
        #2;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #2;
        // R1: reset values
        chk("R1 level", int'(irq_level), 0);
        chk("R1 code", int'(irq_code), 0);
        chk("R1 req", int'(irq_req), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2, R4, R5, R7: 0x1B at source 5 beats 0x1A at source 2
        wr(2, 1, 'h1A);
        wr(5, 1, 'h1B);
        src_req_n = ~8'b0010_0100;
        settle();
        chk("R4 winner code", int'(irq_code), 'h4A0);
        chk("R5 level 0x1B", int'(irq_level), 'hD);
        chk("R7 code src5", int'(irq_code), 'h4A0);

        // R6: exact tie, lower index wins; R2 rewrite takes effect
        wr(5, 1, 'h1A);
        settle();
        chk("R6 tie code", int'(irq_code), 'h440);
        chk("R5 level 0x1A", int'(irq_level), 'hD);
        chk("R2 rewrite", int'(irq_code), 'h440);

        // R3, R8: priorities 1 and 0 mask
        wr(2, 1, 'h01);
        wr(5, 1, 'h00);
        settle();
        chk("R3 level", int'(irq_level), 0);
        chk("R8 code", int'(irq_code), 0);

        // R12: disabled source with top priority ignored
        wr(2, 0, 'h1F);
        wr(5, 1, 'h04);
        settle();
        chk("R12 level", int'(irq_level), 2);
        chk("R12 code", int'(irq_code), 'h4A0);

        // R10: mask and block gating at level 2
        cpu_mask = 4'd2; #1;
        chk("R10 mask equal", int'(irq_req), 0);
        cpu_mask = 4'd1; #1;
        chk("R10 mask below", int'(irq_req), 1);
        cpu_block = 1'b1; #1;
        chk("R10 blocked", int'(irq_req), 0);
        cpu_block = 1'b0;

        // R9 and R11: withdraw line; unchanged before edge, cleared after
        @(negedge clk);
        src_req_n[5] = 1'b1;
        #1;
        chk("R11 before edge", int'(irq_level), 2);
        settle();
        chk("R9 withdrawn", int'(irq_level), 0);
        chk("R9 code", int'(irq_code), 0);
        @(negedge clk);
        src_req_n[5] = 1'b0;
        settle();
        chk("R9 reasserted", int'(irq_level), 2);

        // Mixed pattern: several sources, varied priorities
        wr(0, 1, 'h10);
        wr(7, 1, 'h11);
        wr(3, 1, 'h11);
        src_req_n = ~8'b1010_1001;
        settle();
        chk("R6 tie 3 vs 7", int'(irq_code), 'h460);
        chk("R5 level 0x11", int'(irq_level), 8);

        // R1: reset mid-run clears everything
        @(negedge clk);
        rst_n = 1'b0;
        settle();
        chk("R1 reset again", int'(irq_level), 0);
        chk("R1 reset code", int'(irq_code), 0);
        @(negedge clk);
        rst_n = 1'b1;
        settle();
        chk("R1 cleared cfg", int'(irq_level), 0);

        repeat (2) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule